// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display: a horizontal and a vertical pixel counter, active-high horizontal and vertical sync pulses and a data-enable that marks the visible region. Everything runs in the pixel clock domain. A small word-addressed register port configures it. Each line runs through its visible pixels, then front porch, then sync, then back porch. Each frame steps through its lines in the same order.

Timing values are never written live. Software sets a configuration request and polls a status bit until the block acknowledges it. The block only acknowledges at a frame boundary, so a frame in progress is never disturbed. Software then writes the packed shadow timing registers, clears the request and waits for the acknowledge to drop. Finally it sets a commit bit. The shadow values move into the working registers at the next frame start, and the commit bit then clears itself.

A frame-start event is latched as a pending interrupt. It is cleared by writing ones, and it reaches the interrupt line only when its mask bit is set. A 24-bit channel-depth register holds the per-channel output bit depth. It resets to 8 bits for each of three channels.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the control (word 0), status (word 1), commit (word 2), mask (word 3) and channel-depth (word 9) registers read 0, 0, 0, 0 and 0x080808. Both counters read 0, `irq_o` is low, and the timing registers read back their parameter defaults.
- R2: Each line lasts h_act+h_fp+h_sw+h_bp cycles. `pix_x_o` counts 0 upward through the line. `de_o` is high only for x < h_act and y < v_act. `hsync_o` is high for h_act+h_fp <= x < h_act+h_fp+h_sw.
- R3: Each frame lasts v_act+v_fp+v_sw+v_bp lines. `pix_y_o` advances when a line wraps. `vsync_o` is high for whole lines with v_act+v_fp <= y < v_act+v_fp+v_sw.
- R4: Bit 16 of the control register (word 0) holds the configuration request. Bit 16 of the status register (word 1) is the acknowledge. It takes the request value only at the clock edge that ends the frame-start cycle (x=0, y=0), so a change first shows while x=1, y=0.
- R5: Writes to the timing registers (words 5 to 8) and the channel-depth register (word 9) have no effect while the acknowledge is 0.
- R6: The timing registers use this packing, and unused bits read 0. Word 5 holds h_sw in bits 9:0 and v_sw in bits 23:16. Word 6 holds h_fp in bits 11:0 and h_bp in bits 25:16. Word 7 holds v_fp in bits 11:0 and v_bp in bits 23:16. Word 8 holds h_act in bits 12:0 and v_act in bits 28:16. Word 9 holds 24 bits.
- R7: Writing 1 to bit 0 of word 2 sets a commit flag that reads back in bit 0. At the next frame-start edge the shadow timings become the working timings and the flag clears. Without a commit, shadow writes do not change the outputs.
- R8: Bit 0 of word 4 is the frame-start pending flag. It is set at the frame-start edge, and a write with bit 0 set clears it (the set wins if both happen at once). `irq_o` is the pending flag ANDed with mask bit 0 of word 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 4 | register word address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data (combinational on address) |
| irq_o | output | 1 | masked frame-start interrupt |
| hsync_o | output | 1 | horizontal sync, active high |
| vsync_o | output | 1 | vertical sync, active high |
| de_o | output | 1 | data enable |
| pix_x_o | output | 15 | horizontal counter |
| pix_y_o | output | 15 | vertical counter |

## Verification
Counters and the sync and enable outputs change one edge after the counter state, so the bench predicts them per cycle from a model aligned to an observed x=0, y=0 cycle and samples on the falling edge. A register write shows on readback in the cycle after its write edge. The acknowledge, the working-timing load and the pending flag all change at the edge that ends the frame-start cycle, so the bench checks the acknowledge while x=1, y=0 and checks the pending flag and `irq_o` one falling edge after the frame-start sample. A committed timing set is checked from the frame-start cycle onward, because that cycle looks the same under the old and the new values.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int HACT_W  = 13;
    localparam int HFP_W   = 12;
    localparam int HSW_W   = 10;
    localparam int HBP_W   = 10;
    localparam int VACT_W  = 13;
    localparam int VFP_W   = 12;
    localparam int VSW_W   = 8;
    localparam int VBP_W   = 8;
    localparam int CNT_W   = 15;
    localparam int DEPTH_W = 24;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int CFG_BIT = 16;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd1;
    localparam logic [ADDR_W-1:0] A_COMMIT = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd3;
    localparam logic [ADDR_W-1:0] A_IRQ    = 4'd4;
    localparam logic [ADDR_W-1:0] A_SYNC   = 4'd5;
    localparam logic [ADDR_W-1:0] A_HINT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_VINT   = 4'd7;
    localparam logic [ADDR_W-1:0] A_ACTIVE = 4'd8;
    localparam logic [ADDR_W-1:0] A_DEPTH  = 4'd9;

    typedef struct packed {
        logic [HACT_W-1:0] h_act;
        logic [HFP_W-1:0]  h_fp;
        logic [HSW_W-1:0]  h_sw;
        logic [HBP_W-1:0]  h_bp;
        logic [VACT_W-1:0] v_act;
        logic [VFP_W-1:0]  v_fp;
        logic [VSW_W-1:0]  v_sw;
        logic [VBP_W-1:0]  v_bp;
    } timing_t;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis #(
    parameter int CNT_W = 15,
    parameter int ACT_W = 13,
    parameter int FP_W  = 12,
    parameter int SW_W  = 10,
    parameter int BP_W  = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [ACT_W-1:0] act_i,
    input  logic [FP_W-1:0]  fp_i,
    input  logic [SW_W-1:0]  sw_i,
    input  logic [BP_W-1:0]  bp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             active_o,
    output logic             sync_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } axis_t;

    axis_t s_d, s_q;
    logic [CNT_W-1:0] act_end, sync_lo, sync_hi, last;

    always_comb begin
        act_end  = CNT_W'(act_i);
        sync_lo  = act_end + CNT_W'(fp_i);
        sync_hi  = sync_lo + CNT_W'(sw_i);
        last     = sync_hi + CNT_W'(bp_i) - 1'b1;
        wrap_o   = step_i && (s_q.cnt >= last);
        active_o = s_q.cnt < act_end;
        sync_o   = (s_q.cnt >= sync_lo) && (s_q.cnt < sync_hi);
        s_d = s_q;
        if (step_i) begin
            s_d.cnt = wrap_o ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

    // R2
    step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !wrap_o) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
    // R3
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (s_q.cnt == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(s_q.cnt));
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter timing_t RST_TIMING = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              frame_start_i,
    output timing_t           work_o,
    output logic              irq_o
);
    localparam logic [DEPTH_W-1:0] DEPTH_RST = 24'h080808;

    typedef struct packed {
        logic                req;
        logic                ack;
        logic                commit;
        logic                mask;
        logic                pend;
        logic [DEPTH_W-1:0]  depth;
        timing_t             shadow;
        timing_t             work;
    } regs_t;

    regs_t s_d, s_q;
    logic  commit_wr;
    logic  unused_wdata;

    assign commit_wr    = reg_we_i && (reg_addr_i == A_COMMIT) && reg_wdata_i[0];
    assign unused_wdata = ^reg_wdata_i[31:29];

    always_comb begin
        s_d = s_q;
        if (reg_we_i && (reg_addr_i == A_IRQ) && reg_wdata_i[0]) s_d.pend = 1'b0;
        if (frame_start_i) begin
            s_d.ack  = s_q.req;
            s_d.pend = 1'b1;
            if (s_q.commit) begin
                s_d.work   = s_q.shadow;
                s_d.commit = 1'b0;
            end
        end
        if (commit_wr) s_d.commit = 1'b1;
        if (reg_we_i) begin
            case (reg_addr_i)
                A_CTRL: s_d.req  = reg_wdata_i[CFG_BIT];
                A_MASK: s_d.mask = reg_wdata_i[0];
                default: ;
            endcase
            if (s_q.ack) begin
                case (reg_addr_i)
                    A_SYNC: begin
                        s_d.shadow.h_sw = reg_wdata_i[HSW_W-1:0];
                        s_d.shadow.v_sw = reg_wdata_i[16 +: VSW_W];
                    end
                    A_HINT: begin
                        s_d.shadow.h_fp = reg_wdata_i[HFP_W-1:0];
                        s_d.shadow.h_bp = reg_wdata_i[16 +: HBP_W];
                    end
                    A_VINT: begin
                        s_d.shadow.v_fp = reg_wdata_i[VFP_W-1:0];
                        s_d.shadow.v_bp = reg_wdata_i[16 +: VBP_W];
                    end
                    A_ACTIVE: begin
                        s_d.shadow.h_act = reg_wdata_i[HACT_W-1:0];
                        s_d.shadow.v_act = reg_wdata_i[16 +: VACT_W];
                    end
                    A_DEPTH: s_d.depth = reg_wdata_i[DEPTH_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.depth  <= DEPTH_RST;
            s_q.shadow <= RST_TIMING;
            s_q.work   <= RST_TIMING;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CTRL:   reg_rdata_o[CFG_BIT] = s_q.req;
            A_STATUS: reg_rdata_o[CFG_BIT] = s_q.ack;
            A_COMMIT: reg_rdata_o[0] = s_q.commit;
            A_MASK:   reg_rdata_o[0] = s_q.mask;
            A_IRQ:    reg_rdata_o[0] = s_q.pend;
            A_SYNC: begin
                reg_rdata_o[HSW_W-1:0]   = s_q.shadow.h_sw;
                reg_rdata_o[16 +: VSW_W] = s_q.shadow.v_sw;
            end
            A_HINT: begin
                reg_rdata_o[HFP_W-1:0]   = s_q.shadow.h_fp;
                reg_rdata_o[16 +: HBP_W] = s_q.shadow.h_bp;
            end
            A_VINT: begin
                reg_rdata_o[VFP_W-1:0]   = s_q.shadow.v_fp;
                reg_rdata_o[16 +: VBP_W] = s_q.shadow.v_bp;
            end
            A_ACTIVE: begin
                reg_rdata_o[HACT_W-1:0]   = s_q.shadow.h_act;
                reg_rdata_o[16 +: VACT_W] = s_q.shadow.v_act;
            end
            A_DEPTH:  reg_rdata_o[DEPTH_W-1:0] = s_q.depth;
            default: ;
        endcase
    end

    assign work_o = s_q.work;
    assign irq_o  = s_q.pend & s_q.mask;

    // R4
    ack_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> $stable(s_q.ack));
    // R5
    shadow_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && !s_q.ack) |=> ($stable(s_q.shadow) && $stable(s_q.depth)));
    // R7
    commit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_start_i && s_q.commit && !commit_wr) |=>
            (!s_q.commit && (s_q.work == $past(s_q.shadow))));
    // R7
    work_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> $stable(s_q.work));
    // R8
    irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_i |=> s_q.pend);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int DEF_H_ACT = 8,
    parameter int DEF_H_FP  = 2,
    parameter int DEF_H_SW  = 3,
    parameter int DEF_H_BP  = 1,
    parameter int DEF_V_ACT = 4,
    parameter int DEF_V_FP  = 1,
    parameter int DEF_V_SW  = 2,
    parameter int DEF_V_BP  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  pix_x_o,
    output logic [CNT_W-1:0]  pix_y_o
);
    localparam timing_t RST_T = '{
        h_act: HACT_W'(DEF_H_ACT), h_fp: HFP_W'(DEF_H_FP),
        h_sw:  HSW_W'(DEF_H_SW),   h_bp: HBP_W'(DEF_H_BP),
        v_act: VACT_W'(DEF_V_ACT), v_fp: VFP_W'(DEF_V_FP),
        v_sw:  VSW_W'(DEF_V_SW),   v_bp: VBP_W'(DEF_V_BP)
    };

    timing_t work;
    logic    frame_start;
    logic    h_wrap, h_act, v_act, v_wrap_unused;

    dtg_regs #(.RST_TIMING(RST_T)) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .reg_we_i      (reg_we_i),
        .reg_addr_i    (reg_addr_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .frame_start_i (frame_start),
        .work_o        (work),
        .irq_o         (irq_o)
    );

    dtg_axis #(.CNT_W(CNT_W), .ACT_W(HACT_W), .FP_W(HFP_W), .SW_W(HSW_W), .BP_W(HBP_W)) u_hax (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (1'b1),
        .act_i    (work.h_act),
        .fp_i     (work.h_fp),
        .sw_i     (work.h_sw),
        .bp_i     (work.h_bp),
        .cnt_o    (pix_x_o),
        .wrap_o   (h_wrap),
        .active_o (h_act),
        .sync_o   (hsync_o)
    );

    dtg_axis #(.CNT_W(CNT_W), .ACT_W(VACT_W), .FP_W(VFP_W), .SW_W(VSW_W), .BP_W(VBP_W)) u_vax (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (h_wrap),
        .act_i    (work.v_act),
        .fp_i     (work.v_fp),
        .sw_i     (work.v_sw),
        .bp_i     (work.v_bp),
        .cnt_o    (pix_y_o),
        .wrap_o   (v_wrap_unused),
        .active_o (v_act),
        .sync_o   (vsync_o)
    );

    assign frame_start = (pix_x_o == '0) && (pix_y_o == '0);
    assign de_o        = h_act && v_act;
endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, hs, vs, de;
    logic [14:0] px, py;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    disp_timing_gen u_disp_timing_gen (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_x_o(px), .pix_y_o(py)
    );

    localparam int NV = 10;
    localparam logic [3:0] V_ADDR [NV] = '{4'd5, 4'd6, 4'd7, 4'd8, 4'd9,
                                           4'd5, 4'd6, 4'd7, 4'd8, 4'd9};
    localparam logic [31:0] V_WR [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00010002,
                                          32'h00020001, 32'h00010002, 32'h00030005,
                                          32'h00080808};
    localparam logic [31:0] V_EXP [NV] = '{32'h00FF03FF, 32'h03FF0FFF, 32'h00FF0FFF,
                                           32'h1FFF1FFF, 32'h00FFFFFF, 32'h00010002,
                                           32'h00020001, 32'h00010002, 32'h00030005,
                                           32'h00080808};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!(px == 0 && py == 0));
    endtask

    task automatic poll_ack(input logic want, input string tag);
        logic [31:0] d;
        int n = 0;
        rd(4'd1, d);
        while (d[16] !== want && n < 1000) begin
            @(negedge clk);
            rd(4'd1, d);
            n++;
        end
        chk({tag, " ack value"}, {31'd0, d[16]}, {31'd0, want});
        chk({tag, " ack at x=1,y=0"}, {px, py}, {15'd1, 15'd0});
    endtask

    task automatic check_frame(input int ha, input int hf, input int hw, input int hb,
                               input int va, input int vf, input int vw, input int vb,
                               input int nfr, input string tag);
        int ht = ha + hf + hw + hb;
        int vt = va + vf + vw + vb;
        int eh = 0;
        int ev = 0;
        for (int k = 0; k < ht * vt * nfr; k++) begin
            int x = k % ht;
            int y = (k / ht) % vt;
            logic xde = (x < ha) && (y < va);
            logic xhs = (x >= ha + hf) && (x < ha + hf + hw);
            logic xvs = (y >= va + vf) && (y < va + vf + vw);
            if ((px !== 15'(x) || hs !== xhs || de !== xde) && eh == 0)
                $display("FAIL R2 %s k=%0d actual x=%0d hs=%b de=%b expected x=%0d hs=%b de=%b",
                         tag, k, px, hs, de, x, xhs, xde);
            if (px !== 15'(x) || hs !== xhs || de !== xde) eh++;
            if ((py !== 15'(y) || vs !== xvs) && ev == 0)
                $display("FAIL R3 %s k=%0d actual y=%0d vs=%b expected y=%0d vs=%b",
                         tag, k, py, vs, y, xvs);
            if (py !== 15'(y) || vs !== xvs) ev++;
            @(negedge clk);
        end
        checks += 2;
        if (eh != 0) failures++;
        if (ev != 0) failures++;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pix_x", {17'd0, px}, 32'd0);
        chk("R1 pix_y", {17'd0, py}, 32'd0);
        chk("R1 irq_o", {31'd0, irq}, 32'd0);
        rd(4'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(4'd1, d); chk("R1 status", d, 32'd0);
        rd(4'd2, d); chk("R1 commit", d, 32'd0);
        rd(4'd3, d); chk("R1 mask", d, 32'd0);
        rd(4'd9, d); chk("R1 depth", d, 32'h00080808);
        rd(4'd5, d); chk("R1 sync default", d, 32'h00020003);
        rd(4'd8, d); chk("R1 active default", d, 32'h00040008);

        // R2 R3 default raster
        wait_fs();
        check_frame(8, 2, 3, 1, 4, 1, 2, 1, 2, "default");

        // R5 shadow write ignored outside configuration mode
        wr(4'd5, 32'h00110011);
        rd(4'd5, d); chk("R5 sync ignored", d, 32'h00020003);
        wr(4'd9, 32'h00000001);
        rd(4'd9, d); chk("R5 depth ignored", d, 32'h00080808);

        // R4 enter configuration mode
        wr(4'd0, 32'h00010000);
        rd(4'd0, d); chk("R4 ctrl readback", d, 32'h00010000);
        rd(4'd1, d); chk("R4 ack not immediate", d, 32'd0);
        poll_ack(1'b1, "R4 enter");

        // R6 packing table
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WR[i]);
            rd(V_ADDR[i], d);
            chk($sformatf("R6 vector %0d", i), d, V_EXP[i]);
        end

        // R4 leave configuration mode
        wr(4'd0, 32'h00000000);
        poll_ack(1'b0, "R4 leave");

        // R7 no commit -> old timings remain
        wait_fs();
        check_frame(8, 2, 3, 1, 4, 1, 2, 1, 1, "R7 before commit");
        wr(4'd2, 32'h00000001);
        rd(4'd2, d); chk("R7 commit pending", d, 32'd1);
        wait_fs();
        check_frame(5, 1, 2, 2, 3, 2, 1, 1, 2, "R7 after commit");
        rd(4'd2, d); chk("R7 commit self-clear", d, 32'd0);

        // R8 interrupt
        wait_fs();
        @(negedge clk);
        wr(4'd3, 32'd0);
        wr(4'd4, 32'hFFFFFFFF);
        rd(4'd4, d); chk("R8 pending cleared", d, 32'd0);
        wait_fs();
        rd(4'd4, d); chk("R8 pending before edge", d, 32'd0);
        @(negedge clk);
        rd(4'd4, d); chk("R8 pending set at frame start", d, 32'd1);
        chk("R8 masked irq low", {31'd0, irq}, 32'd0);
        wr(4'd3, 32'd1);
        chk("R8 unmasked irq high", {31'd0, irq}, 32'd1);
        wr(4'd4, 32'd1);
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);
        rd(4'd4, d); chk("R8 pending after clear", d, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule